// File: doc/BRIEF.md
# Universal Serial Shift Interface

This block is a small serial engine for building serial links in firmware. Its core is a shift register that shifts left, taking the newest bit from the data line at the bottom. Next to it sits a buffer that captures each completed byte, and a small edge counter that marks when a byte is done. The shift and count events can come from three places: a software strobe written to the control register, an on-chip timer tick, or edges seen on the serial clock pin after a synchronizer. The most significant bit of the shift register always drives the data output.

Two line styles are supported. In three-wire mode the data output pin is driven directly, so the block can act as either end of an SPI-like link. In two-wire mode the data and clock lines are open drain: the block only pulls them low. The block also watches for a start condition, and it can hold the clock line low until software has handled the event. Addressing, acknowledge and every other protocol step are left to software, which talks to the block through four byte-wide registers.

Top module: `ushift_core`

## Requirements
- R1: After synchronous reset, all four registers read 0x00 and the outputs sd_out, sd_pull, sc_pull, irq_start and irq_ovf are low.
- R2: Register map by reg_addr: 0 = shift data (read/write), 1 = byte buffer (read only, writes have no effect), 2 = status {bit7 start flag, bit6 overflow flag, bits 3:0 edge counter}, 3 = control {bit7 start irq enable, bit6 overflow irq enable, bits 5:4 line mode, bits 3:2 clock source, bit1 count strobe, bit0 shift strobe}. The strobe bits always read as 0.
- R3: On every shift event the data register moves left by one position, and its bit 0 takes the synchronized level of sd_in.
- R4: Writing control with bit0 set causes one shift and one count at that write. Writing control with bit1 set causes one count and no shift.
- R5: With clock source 01 (timer), each cycle in which timer_tick is high causes one shift and one count, as long as the line mode is not 00 (off).
- R6: With clock source 10, a rising edge of the synchronized sc_in shifts and counts, and a falling edge only counts. Source 11 swaps the two edges. With the counter loaded to 0, the overflow comes at the sixteenth edge, which is the edge that completes the eighth bit.
- R7: When a count moves the counter from 15 to 0, the overflow flag is set and the buffer captures the data register value as updated by that same event.
- R8: A write to status clears the start flag if bit7 = 1 and the overflow flag if bit6 = 1; a 0 in either bit leaves that flag as it is. The same write loads the counter from bits 3:0.
- R9: In line modes 10 and 11 (two-wire), a fall of the synchronized sd_in while the synchronized sc_in is high sets the start flag. A fall while sc_in is low does not. In mode 01 no start flag is ever set.
- R10: In two-wire modes, sc_pull is high while the start flag is set. In mode 11 it is also high while the overflow flag is set. In mode 10 the overflow flag does not pull the clock line.
- R11: In mode 01, sd_out equals the data register MSB. In two-wire modes, sd_pull is high exactly when the MSB is 0. Otherwise both outputs are 0.
- R12: irq_start is high when the start flag and its enable are both set, and irq_ovf is high when the overflow flag and its enable are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| timer_tick | input | 1 | One-cycle clock pulse from a timer |
| sd_in | input | 1 | Serial data line level |
| sc_in | input | 1 | Serial clock line level |
| sd_out | output | 1 | Three-wire data output |
| sd_pull | output | 1 | Two-wire data line pull-low |
| sc_pull | output | 1 | Two-wire clock line hold (pull-low) |
| irq_start | output | 1 | Start condition interrupt |
| irq_ovf | output | 1 | Counter overflow interrupt |

## Verification
The bench builds the block with its default parameters: an 8-bit data register, a 4-bit counter and two synchronizer stages. With these values a full byte of sixteen pin edges can be driven in well under a thousand cycles. The counter wrap from 15 to 0 can be reached with a single count after a status load. The two-stage synchronizer fixes the input latency at a known three cycles, so the bench can hold the pins stable for a fixed count of cycles before each check.

// File: rtl/ushift_pkg.sv
package ushift_pkg;

    localparam int CTRL_W         = 8;
    localparam int STAT_START_BIT = 7;
    localparam int STAT_OVF_BIT   = 6;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'b00,
        MODE_3W      = 2'b01,
        MODE_2W      = 2'b10,
        MODE_2W_HOLD = 2'b11
    } line_mode_e;

    typedef enum logic [1:0] {
        SRC_SOFT     = 2'b00,
        SRC_TIMER    = 2'b01,
        SRC_EXT_RISE = 2'b10,
        SRC_EXT_FALL = 2'b11
    } clk_src_e;

    typedef enum logic [1:0] {
        ADDR_DATA = 2'd0,
        ADDR_BUF  = 2'd1,
        ADDR_STAT = 2'd2,
        ADDR_CTRL = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic       start_ie;
        logic       ovf_ie;
        line_mode_e mode;
        clk_src_e   src;
        logic       cnt_stb;
        logic       shift_stb;
    } ctrl_t;

    typedef struct packed {
        logic shift;
        logic count;
    } clk_evt_t;

    function automatic logic is_two_wire(line_mode_e m);
        return m[1];
    endfunction

    function automatic logic holds_on_ovf(line_mode_e m);
        return m == MODE_2W_HOLD;
    endfunction

    // strobes act once and are never stored
    function automatic ctrl_t ctrl_store(logic [CTRL_W-1:0] w);
        ctrl_t c;
        c           = ctrl_t'(w);
        c.cnt_stb   = 1'b0;
        c.shift_stb = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/ushift_sync.sv
module ushift_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] stg;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg  <= {STAGES{RESET_VAL}};
            prev <= RESET_VAL;
        end else begin
            stg[0] <= pin;
            for (int k = 1; k < STAGES; k++) begin
                stg[k] <= stg[k-1];
            end
            prev <= stg[STAGES-1];
        end
    end

    assign level = stg[STAGES-1];
    assign rise  = level & ~prev;
    assign fall  = ~level & prev;
endmodule

// File: rtl/ushift_evt.sv
module ushift_evt
    import ushift_pkg::*;
(
    input  clk_src_e   src,
    input  line_mode_e mode,
    input  logic       timer_tick,
    input  logic       ext_rise,
    input  logic       ext_fall,
    input  logic       sw_shift,
    input  logic       sw_count,
    output clk_evt_t   evt
);
    logic hw_shift;
    logic hw_count;

    always_comb begin
        hw_shift = 1'b0;
        hw_count = 1'b0;
        unique case (src)
            SRC_TIMER: begin
                hw_shift = timer_tick;
                hw_count = timer_tick;
            end
            SRC_EXT_RISE: begin
                hw_shift = ext_rise;
                hw_count = ext_rise | ext_fall;
            end
            SRC_EXT_FALL: begin
                hw_shift = ext_fall;
                hw_count = ext_rise | ext_fall;
            end
            default: ;
        endcase
        if (mode == MODE_OFF) begin
            hw_shift = 1'b0;
            hw_count = 1'b0;
        end
        evt.shift = hw_shift | sw_shift;
        evt.count = hw_count | sw_shift | sw_count;
    end
endmodule

// File: rtl/ushift_counter.sv
module ushift_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    assign wrap = inc & ~load & (cnt == CNT_TOP);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else if (inc)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ushift_datapath.sv
module ushift_datapath #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              shift,
    input  logic              din,
    input  logic              capture,
    output logic [DATA_W-1:0] data_q,
    output logic [DATA_W-1:0] buf_q
);
    logic [DATA_W-1:0] data_nxt;

    always_comb begin
        if (load)       data_nxt = load_val;
        else if (shift) data_nxt = {data_q[DATA_W-2:0], din};
        else            data_nxt = data_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            buf_q  <= '0;
        end else begin
            data_q <= data_nxt;
            if (capture) buf_q <= data_nxt;
        end
    end
endmodule

// File: rtl/ushift_flags.sv
module ushift_flags (
    input  logic clk,
    input  logic rst,
    input  logic set_start,
    input  logic clr_start,
    input  logic set_ovf,
    input  logic clr_ovf,
    output logic start_q,
    output logic ovf_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
            ovf_q   <= 1'b0;
        end else begin
            start_q <= set_start | (start_q & ~clr_start);
            ovf_q   <= set_ovf   | (ovf_q   & ~clr_ovf);
        end
    end
endmodule

// File: rtl/ushift_core.sv
module ushift_core
    import ushift_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              timer_tick,
    input  logic              sd_in,
    input  logic              sc_in,
    output logic              sd_out,
    output logic              sd_pull,
    output logic              sc_pull,
    output logic              irq_start,
    output logic              irq_ovf
);
    localparam int MSB = DATA_W - 1;

    ctrl_t             ctrl_q;
    clk_evt_t          evt;
    reg_addr_e         addr;
    logic              wr_data, wr_stat, wr_ctrl;
    logic              sd_lvl, sd_rise, sd_fall;
    logic              sc_lvl, sc_rise, sc_fall;
    logic [CNT_W-1:0]  cnt_q;
    logic              cnt_wrap;
    logic [DATA_W-1:0] data_q, buf_q;
    logic              start_q, ovf_q;
    logic              two_wire;
    logic              start_det;
    logic [DATA_W-1:0] stat_rd, ctrl_rd;

    assign addr     = reg_addr_e'(reg_addr);
    assign wr_data  = reg_wr && (addr == ADDR_DATA);
    assign wr_stat  = reg_wr && (addr == ADDR_STAT);
    assign wr_ctrl  = reg_wr && (addr == ADDR_CTRL);
    assign two_wire = is_two_wire(ctrl_q.mode);

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_store(reg_wdata[CTRL_W-1:0]);
    end

    ushift_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sd_sync (
        .clk(clk), .rst(rst), .pin(sd_in),
        .level(sd_lvl), .rise(sd_rise), .fall(sd_fall)
    );

    ushift_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sc_sync (
        .clk(clk), .rst(rst), .pin(sc_in),
        .level(sc_lvl), .rise(sc_rise), .fall(sc_fall)
    );

    ushift_evt u_evt (
        .src       (ctrl_q.src),
        .mode      (ctrl_q.mode),
        .timer_tick(timer_tick),
        .ext_rise  (sc_rise),
        .ext_fall  (sc_fall),
        .sw_shift  (wr_ctrl & reg_wdata[0]),
        .sw_count  (wr_ctrl & reg_wdata[1]),
        .evt       (evt)
    );

    ushift_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .load    (wr_stat),
        .load_val(reg_wdata[CNT_W-1:0]),
        .inc     (evt.count),
        .cnt     (cnt_q),
        .wrap    (cnt_wrap)
    );

    ushift_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk     (clk),
        .rst     (rst),
        .load    (wr_data),
        .load_val(reg_wdata),
        .shift   (evt.shift),
        .din     (sd_lvl),
        .capture (cnt_wrap),
        .data_q  (data_q),
        .buf_q   (buf_q)
    );

    // start: data line falls while clock line stays high
    assign start_det = two_wire & sd_fall & sc_lvl;

    ushift_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_start(start_det),
        .clr_start(wr_stat & reg_wdata[STAT_START_BIT]),
        .set_ovf  (cnt_wrap),
        .clr_ovf  (wr_stat & reg_wdata[STAT_OVF_BIT]),
        .start_q  (start_q),
        .ovf_q    (ovf_q)
    );

    always_comb begin
        stat_rd                 = '0;
        stat_rd[STAT_START_BIT] = start_q;
        stat_rd[STAT_OVF_BIT]   = ovf_q;
        stat_rd[CNT_W-1:0]      = cnt_q;
        ctrl_rd                 = '0;
        ctrl_rd[CTRL_W-1:0]     = ctrl_q;
    end

    always_comb begin
        unique case (addr)
            ADDR_DATA: reg_rdata = data_q;
            ADDR_BUF:  reg_rdata = buf_q;
            ADDR_STAT: reg_rdata = stat_rd;
            default:   reg_rdata = ctrl_rd;
        endcase
    end

    assign sd_out    = (ctrl_q.mode == MODE_3W) & data_q[MSB];
    assign sd_pull   = two_wire & ~data_q[MSB];
    assign sc_pull   = two_wire & (start_q | (holds_on_ovf(ctrl_q.mode) & ovf_q));
    assign irq_start = start_q & ctrl_q.start_ie;
    assign irq_ovf   = ovf_q & ctrl_q.ovf_ie;
endmodule

// File: rtl/ushift_chk.sv
module ushift_chk #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [CNT_W-1:0]  cnt,
    input logic              cnt_inc,
    input logic              cnt_ld,
    input logic              ovf_flag,
    input logic              start_flag,
    input logic [DATA_W-1:0] buf_q,
    input logic              two_wire,
    input logic              sd_out,
    input logic              sd_pull,
    input logic              sc_pull,
    input logic              irq_start,
    input logic              irq_ovf
);
    // R1
    rst_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cnt == '0));

    // R7
    wrap_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == {CNT_W{1'b1}} && cnt_inc && !cnt_ld) |=> ovf_flag);

    // R7
    buf_upd_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(buf_q) |-> ovf_flag);

    // R9
    start_mode_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(start_flag) |-> $past(two_wire));

    // R10
    hold_start_chk: assert property (@(posedge clk) disable iff (rst)
        (two_wire && start_flag) |-> sc_pull);

    // R11
    pull_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(sd_pull && sd_out));

    // R12
    irq_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        irq_ovf |-> ovf_flag);

    // R12
    irq_start_chk: assert property (@(posedge clk) disable iff (rst)
        irq_start |-> start_flag);
endmodule

bind ushift_core ushift_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cnt       (cnt_q),
    .cnt_inc   (evt.count),
    .cnt_ld    (wr_stat),
    .ovf_flag  (ovf_q),
    .start_flag(start_q),
    .buf_q     (buf_q),
    .two_wire  (two_wire),
    .sd_out    (sd_out),
    .sd_pull   (sd_pull),
    .sc_pull   (sc_pull),
    .irq_start (irq_start),
    .irq_ovf   (irq_ovf)
);

// File: tb/test_ushift_core.sv
`timescale 1ns/1ps
module test_ushift_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       timer_tick = 1'b0;
    logic       sd_in = 1'b1;
    logic       sc_in = 1'b1;
    logic       sd_out, sd_pull, sc_pull, irq_start, irq_ovf;

    int n_chk = 0;
    int n_err = 0;

    localparam logic [15:0] VECS [6] = '{16'hA53C, 16'h00FF, 16'hFF00,
                                        16'h817E, 16'h5AC3, 16'h1234};

    always #2.5 clk = ~clk;

    ushift_core i_ushift_core (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .timer_tick(timer_tick),
        .sd_in(sd_in), .sc_in(sc_in), .sd_out(sd_out), .sd_pull(sd_pull),
        .sc_pull(sc_pull), .irq_start(irq_start), .irq_ovf(irq_ovf)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic tick();
        @(negedge clk); timer_tick = 1'b1;
        @(negedge clk); timer_tick = 1'b0;
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        idle(2);

        // R1 reset state
        rd_chk(2'd0, 8'h00, "R1 data");
        rd_chk(2'd1, 8'h00, "R1 buffer");
        rd_chk(2'd2, 8'h00, "R1 status");
        rd_chk(2'd3, 8'h00, "R1 control");
        chk("R1 outputs", {3'b0, sd_out, sd_pull, sc_pull, irq_start, irq_ovf}, 8'h00);

        // R2 map, R3/R4 strobes
        wr(2'd0, 8'hC3);
        rd_chk(2'd0, 8'hC3, "R2 data readback");
        wr(2'd3, 8'h01);
        rd_chk(2'd0, 8'h87, "R4 shift strobe data (R3 lsb from sd_in)");
        rd_chk(2'd2, 8'h01, "R4 shift strobe count");
        wr(2'd3, 8'h02);
        rd_chk(2'd0, 8'h87, "R4 count strobe keeps data");
        rd_chk(2'd2, 8'h02, "R4 count strobe count");
        rd_chk(2'd3, 8'h00, "R2 strobes read zero");
        wr(2'd1, 8'h55);
        rd_chk(2'd1, 8'h00, "R2 buffer write ignored");

        // vector table: timer clocked, three-wire
        wr(2'd3, 8'h14);
        rd_chk(2'd3, 8'h14, "R2 control readback");
        for (int v = 0; v < 6; v++) begin
            logic [7:0] tx, rx;
            tx = VECS[v][15:8];
            rx = VECS[v][7:0];
            wr(2'd0, tx);
            wr(2'd2, 8'hC8);
            for (int i = 0; i < 8; i++) begin
                sd_in = rx[7-i];
                idle(3);
                chk("R11 sd_out is msb", {7'b0, sd_out}, {7'b0, tx[7-i]});
                tick();
            end
            idle(1);
            rd_chk(2'd1, rx, "R7 buffer after byte (R5 timer)");
            rd_chk(2'd0, rx, "R3 data after byte");
            rd_chk(2'd2, 8'h40, "R7 overflow flag, R9 no start in three-wire");
        end

        // R8 clear and load
        wr(2'd2, 8'h45);
        rd_chk(2'd2, 8'h05, "R8 clear ovf and load counter");

        // R12 overflow irq
        wr(2'd3, 8'h54);
        wr(2'd2, 8'h0F);
        tick();
        rd_chk(2'd2, 8'h40, "R7 wrap from 15");
        chk("R12 irq_ovf high", {7'b0, irq_ovf}, 8'h01);
        chk("R12 irq_start low", {7'b0, irq_start}, 8'h00);
        wr(2'd2, 8'h03);
        rd_chk(2'd2, 8'h43, "R8 zero bit keeps flag");
        wr(2'd2, 8'h40);
        rd_chk(2'd2, 8'h00, "R8 one bit clears flag");
        chk("R12 irq_ovf low", {7'b0, irq_ovf}, 8'h00);

        // R6 external rising-edge sampling, byte B2
        sc_in = 1'b0;
        idle(4);
        wr(2'd3, 8'h18);
        wr(2'd0, 8'h00);
        wr(2'd2, 8'hC0);
        for (int i = 0; i < 8; i++) begin
            logic [7:0] b;
            b = 8'hB2;
            sd_in = b[7-i];
            idle(3);
            sc_in = 1'b1;
            idle(4);
            if (i == 7) rd_chk(2'd2, 8'h0F, "R6 fifteen edges no overflow");
            sc_in = 1'b0;
            idle(4);
        end
        rd_chk(2'd2, 8'h40, "R6 overflow at sixteenth edge");
        rd_chk(2'd1, 8'hB2, "R6 rising-edge byte");

        // R6 external falling-edge sampling, byte 4D
        wr(2'd3, 8'h1C);
        wr(2'd2, 8'hC0);
        wr(2'd0, 8'h00);
        for (int i = 0; i < 8; i++) begin
            logic [7:0] b;
            b = 8'h4D;
            sc_in = 1'b1;
            idle(4);
            if (i == 0) begin
                rd_chk(2'd0, 8'h00, "R6 rise counts only, data kept");
                rd_chk(2'd2, 8'h01, "R6 rise counted");
            end
            sd_in = b[7-i];
            idle(3);
            sc_in = 1'b0;
            idle(4);
        end
        rd_chk(2'd1, 8'h4D, "R6 falling-edge byte");
        rd_chk(2'd2, 8'h40, "R6 falling overflow");

        // R9 / R10 two-wire start
        wr(2'd3, 8'hA0);
        sd_in = 1'b1; sc_in = 1'b1;
        idle(4);
        wr(2'd2, 8'hC0);
        rd_chk(2'd2, 8'h00, "R9 idle no start");
        sd_in = 1'b0;
        idle(4);
        rd_chk(2'd2, 8'h80, "R9 start detected");
        chk("R10 hold on start", {7'b0, sc_pull}, 8'h01);
        chk("R12 irq_start high", {7'b0, irq_start}, 8'h01);
        wr(2'd2, 8'h80);
        rd_chk(2'd2, 8'h00, "R8 start cleared");
        chk("R10 release after clear", {7'b0, sc_pull}, 8'h00);
        sc_in = 1'b0; idle(4);
        sd_in = 1'b1; idle(4);
        sd_in = 1'b0; idle(4);
        rd_chk(2'd2, 8'h00, "R9 no start when clock low");
        sc_in = 1'b1; idle(4);

        // R11 open-drain data
        wr(2'd0, 8'h7F);
        chk("R11 sd_pull when msb 0", {6'b0, sd_pull, sd_out}, 8'h02);
        wr(2'd0, 8'h80);
        chk("R11 sd_pull released when msb 1", {6'b0, sd_pull, sd_out}, 8'h00);

        // R10 hold on overflow only in mode 11
        wr(2'd3, 8'h30);
        wr(2'd2, 8'h0F);
        wr(2'd3, 8'h32);
        rd_chk(2'd2, 8'h40, "R10 overflow in mode 11");
        chk("R10 hold on overflow", {7'b0, sc_pull}, 8'h01);
        wr(2'd2, 8'h40);
        chk("R10 release after ovf clear", {7'b0, sc_pull}, 8'h00);
        wr(2'd2, 8'h0F);
        wr(2'd3, 8'h22);
        rd_chk(2'd2, 8'h40, "R10 overflow in mode 10");
        chk("R10 no hold on overflow in mode 10", {7'b0, sc_pull}, 8'h00);

        report();
        $finish;
    end
endmodule